// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date as separate 4-bit BCD digits. It holds seconds, minutes, hours, day of month, month and a two-digit year, each as a tens and a units nibble, plus a day-of-week digit. An internal prescaler divides the clock down to a once-per-second enable that steps the digits. Day rollover follows the month length, February has 29 days in the leap position of a four-year cycle, and hours count in either 24-hour or 12-hour form with an afternoon flag.

The host reads any digit through a combinational nibble read port. It loads any digit, the hour-mode bit or the leap phase through a nibble write port, but only while counting is halted. A second that falls due while counting is halted is held and applied when counting resumes. A prescaler clear input restarts the sub-second division, so the next second arrives a full period later.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the digits read 00:00:00, day 01, month 01, year 00, weekday 0; the hour-mode bit reads 1 (24-hour) and the leap phase reads 0.
- R2: While running, the seconds advance once every TICK_DIV clock cycles; seconds 59 become 00 and carry into the minutes, and minutes 59 become 00 and carry into the hours.
- R3: With the hour-mode bit set, hours count 00 to 23 and 23 rolls to 00 with a carry into the day.
- R4: With the hour-mode bit clear, the hours tens nibble holds the tens digit in bit 0 and the PM flag in bit 1; hours run 12, 01 ... 11; 11 to 12 toggles PM, and the day advances only when PM goes from 1 to 0.
- R5: Months 04, 06, 09 and 11 end after day 30, other months except 02 after day 31; the day then returns to 01 and the month advances, and month 12 returns to 01 with a carry into the year.
- R6: February ends after day 29 when the leap phase is 0 and after day 28 otherwise; each year step adds 1 modulo 4 to the leap phase, and year 99 rolls to 00.
- R7: The weekday digit advances on every day rollover and wraps from 6 to 0.
- R8: Bank 0 addresses 0 to 12 are seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, weekday, day units, day tens, month units, month tens, year units, year tens; bank 1 address 10 bit 0 is the hour-mode bit and address 11 bits 1:0 the leap phase. A write takes effect only while runEn is low and is ignored while runEn is high.
- R9: While runEn is low no digit changes except by a write; any number of seconds that fall due while halted are applied as exactly one step on the first running cycle.
- R10: When a held second and a freshly generated second meet in the same running cycle, the digits step in that cycle and again in the next one.
- R11: divReset clears the prescaler so the next second falls due TICK_DIV cycles after it; a divReset in the cycle a second would fall due suppresses that second.
- R12: rdData follows rdBank and rdAddr combinationally; bank 0 addresses 13 to 15 and every bank 1 address other than 10 and 11 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Counting enabled when high; writes accepted when low |
| divReset | input | 1 | Clears the sub-second prescaler |
| wrEn | input | 1 | Nibble write strobe |
| wrBank | input | 1 | Write bank: 0 digits, 1 configuration |
| wrAddr | input | 4 | Write nibble address |
| wrData | input | 4 | Write nibble data |
| rdBank | input | 1 | Read bank: 0 digits, 1 configuration |
| rdAddr | input | 4 | Read nibble address |
| rdData | output | 4 | Read nibble data |

## Verification
The held second released by re-enabling counting can fall in the same cycle as a freshly generated second, and a prescaler clear can fall in the very cycle a second is due. The bench provokes the first by halting long enough to hold a second and then raising runEn exactly when its own prescaler model is at the last count, and the second by pulsing divReset at that same count. Both are judged by comparing every readable nibble against the behavioural model after every clock, so a lost, merged or extra step shows up in the cycle it happens.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_DIGITS = 13;
  localparam int NIB = 4;

  localparam logic [3:0] ADDR_SEC_U = 4'd0;
  localparam logic [3:0] ADDR_SEC_T = 4'd1;
  localparam logic [3:0] ADDR_MIN_U = 4'd2;
  localparam logic [3:0] ADDR_MIN_T = 4'd3;
  localparam logic [3:0] ADDR_HR_U  = 4'd4;
  localparam logic [3:0] ADDR_HR_T  = 4'd5;
  localparam logic [3:0] ADDR_WDAY  = 4'd6;
  localparam logic [3:0] ADDR_DAY_U = 4'd7;
  localparam logic [3:0] ADDR_DAY_T = 4'd8;
  localparam logic [3:0] ADDR_MON_U = 4'd9;
  localparam logic [3:0] ADDR_MON_T = 4'd10;
  localparam logic [3:0] ADDR_YR_U  = 4'd11;
  localparam logic [3:0] ADDR_YR_T  = 4'd12;

  localparam logic [3:0] CFG_HOURMODE = 4'd10;
  localparam logic [3:0] CFG_PHASE    = 4'd11;

  typedef struct packed {
    logic advance;
    logic wrTime;
    logic wrCfg;
  } calStrobes_t;
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        divReset,
  input  logic        wrEn,
  input  logic        wrBank,
  output calStrobes_t strobes
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST_COUNT = CW'(TICK_DIV - 1);

  logic [CW-1:0] preCnt;
  logic          heldSecond;
  logic          termCount;
  logic          secTick;

  assign termCount = (preCnt == LAST_COUNT);
  assign secTick   = termCount && !divReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt     <= '0;
      heldSecond <= 1'b0;
    end else begin
      if (divReset || termCount) preCnt <= '0;
      else                       preCnt <= preCnt + CW'(1);
      // a held second survives one running cycle only if a new one arrives with it
      if (runEn) heldSecond <= heldSecond && secTick;
      else       heldSecond <= heldSecond || secTick;
    end
  end

  always_comb begin
    strobes.advance = runEn && (secTick || heldSecond);
    strobes.wrTime  = wrEn && !runEn && !wrBank;
    strobes.wrCfg   = wrEn && !runEn && wrBank;
  end
endmodule

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  calStrobes_t               st,
  input  logic [3:0]                wrAddr,
  input  logic [3:0]                wrData,
  output logic [NUM_DIGITS*NIB-1:0] digitsFlat,
  output logic                      mode24,
  output logic [1:0]                leapPhase
);
  logic [3:0] dig [NUM_DIGITS];
  logic [3:0] nxt [NUM_DIGITS];
  logic       nxtMode;
  logic [1:0] nxtPhase;
  logic       cMin, cHr, cDay, cMon, cYr;
  logic       isFeb, isThirty, monthEnd, pm, tensBit;

  function automatic logic [3:0] resetDigit(input int idx);
    return (idx == int'(ADDR_DAY_U) || idx == int'(ADDR_MON_U)) ? 4'd1 : 4'd0;
  endfunction

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_flat
    assign digitsFlat[g*NIB +: NIB] = dig[g];
  end

  always_comb begin
    isFeb    = (dig[ADDR_MON_T] == 4'd0) && (dig[ADDR_MON_U] == 4'd2);
    isThirty = ((dig[ADDR_MON_T] == 4'd0) && (dig[ADDR_MON_U] == 4'd4 || dig[ADDR_MON_U] == 4'd6 ||
                                               dig[ADDR_MON_U] == 4'd9)) ||
               ((dig[ADDR_MON_T] == 4'd1) && (dig[ADDR_MON_U] == 4'd1));
    if (isFeb)
      monthEnd = (dig[ADDR_DAY_T] == 4'd2) && (dig[ADDR_DAY_U] == ((leapPhase == 2'd0) ? 4'd9 : 4'd8));
    else if (isThirty)
      monthEnd = (dig[ADDR_DAY_T] == 4'd3) && (dig[ADDR_DAY_U] == 4'd0);
    else
      monthEnd = (dig[ADDR_DAY_T] == 4'd3) && (dig[ADDR_DAY_U] == 4'd1);
    pm      = dig[ADDR_HR_T][1];
    tensBit = dig[ADDR_HR_T][0];
  end

  always_comb begin
    nxt      = dig;
    nxtMode  = mode24;
    nxtPhase = leapPhase;
    cMin = 1'b0; cHr = 1'b0; cDay = 1'b0; cMon = 1'b0; cYr = 1'b0;
    if (st.advance) begin
      if (dig[ADDR_SEC_U] == 4'd9) begin
        nxt[ADDR_SEC_U] = 4'd0;
        if (dig[ADDR_SEC_T] == 4'd5) begin nxt[ADDR_SEC_T] = 4'd0; cMin = 1'b1; end
        else nxt[ADDR_SEC_T] = dig[ADDR_SEC_T] + 4'd1;
      end else nxt[ADDR_SEC_U] = dig[ADDR_SEC_U] + 4'd1;

      if (cMin) begin
        if (dig[ADDR_MIN_U] == 4'd9) begin
          nxt[ADDR_MIN_U] = 4'd0;
          if (dig[ADDR_MIN_T] == 4'd5) begin nxt[ADDR_MIN_T] = 4'd0; cHr = 1'b1; end
          else nxt[ADDR_MIN_T] = dig[ADDR_MIN_T] + 4'd1;
        end else nxt[ADDR_MIN_U] = dig[ADDR_MIN_U] + 4'd1;
      end

      if (cHr) begin
        if (mode24) begin
          if (dig[ADDR_HR_T] == 4'd2 && dig[ADDR_HR_U] == 4'd3) begin
            nxt[ADDR_HR_T] = 4'd0; nxt[ADDR_HR_U] = 4'd0; cDay = 1'b1;
          end else if (dig[ADDR_HR_U] == 4'd9) begin
            nxt[ADDR_HR_U] = 4'd0; nxt[ADDR_HR_T] = dig[ADDR_HR_T] + 4'd1;
          end else nxt[ADDR_HR_U] = dig[ADDR_HR_U] + 4'd1;
        end else begin
          if (tensBit && dig[ADDR_HR_U] == 4'd1) begin
            nxt[ADDR_HR_U] = 4'd2; nxt[ADDR_HR_T] = {2'b00, !pm, 1'b1}; cDay = pm;
          end else if (tensBit && dig[ADDR_HR_U] == 4'd2) begin
            nxt[ADDR_HR_U] = 4'd1; nxt[ADDR_HR_T] = {2'b00, pm, 1'b0};
          end else if (dig[ADDR_HR_U] == 4'd9) begin
            nxt[ADDR_HR_U] = 4'd0; nxt[ADDR_HR_T] = {2'b00, pm, 1'b1};
          end else nxt[ADDR_HR_U] = dig[ADDR_HR_U] + 4'd1;
        end
      end

      if (cDay) begin
        nxt[ADDR_WDAY] = (dig[ADDR_WDAY] == 4'd6) ? 4'd0 : dig[ADDR_WDAY] + 4'd1;
        if (monthEnd) begin
          nxt[ADDR_DAY_U] = 4'd1; nxt[ADDR_DAY_T] = 4'd0; cMon = 1'b1;
        end else if (dig[ADDR_DAY_U] == 4'd9) begin
          nxt[ADDR_DAY_U] = 4'd0; nxt[ADDR_DAY_T] = dig[ADDR_DAY_T] + 4'd1;
        end else nxt[ADDR_DAY_U] = dig[ADDR_DAY_U] + 4'd1;
      end

      if (cMon) begin
        if (dig[ADDR_MON_T] == 4'd1 && dig[ADDR_MON_U] == 4'd2) begin
          nxt[ADDR_MON_U] = 4'd1; nxt[ADDR_MON_T] = 4'd0; cYr = 1'b1;
        end else if (dig[ADDR_MON_U] == 4'd9) begin
          nxt[ADDR_MON_U] = 4'd0; nxt[ADDR_MON_T] = 4'd1;
        end else nxt[ADDR_MON_U] = dig[ADDR_MON_U] + 4'd1;
      end

      if (cYr) begin
        nxtPhase = leapPhase + 2'd1;
        if (dig[ADDR_YR_U] == 4'd9) begin
          nxt[ADDR_YR_U] = 4'd0;
          nxt[ADDR_YR_T] = (dig[ADDR_YR_T] == 4'd9) ? 4'd0 : dig[ADDR_YR_T] + 4'd1;
        end else nxt[ADDR_YR_U] = dig[ADDR_YR_U] + 4'd1;
      end
    end

    if (st.wrTime) begin
      for (int i = 0; i < NUM_DIGITS; i++)
        if (wrAddr == 4'(i)) nxt[i] = wrData;
    end
    if (st.wrCfg) begin
      if (wrAddr == CFG_HOURMODE) nxtMode  = wrData[0];
      if (wrAddr == CFG_PHASE)    nxtPhase = wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIGITS; i++) dig[i] <= resetDigit(i);
      mode24    <= 1'b1;
      leapPhase <= 2'd0;
    end else begin
      for (int i = 0; i < NUM_DIGITS; i++) dig[i] <= nxt[i];
      mode24    <= nxtMode;
      leapPhase <= nxtPhase;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       divReset,
  input  logic       wrEn,
  input  logic       wrBank,
  input  logic [3:0] wrAddr,
  input  logic [3:0] wrData,
  input  logic       rdBank,
  input  logic [3:0] rdAddr,
  output logic [3:0] rdData
);
  calStrobes_t               ctlStrobes;
  logic [NUM_DIGITS*NIB-1:0] digitsFlat;
  logic                      mode24;
  logic [1:0]                leapPhase;

  rtc_cal_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .divReset(divReset),
    .wrEn(wrEn), .wrBank(wrBank), .strobes(ctlStrobes)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(ctlStrobes), .wrAddr(wrAddr), .wrData(wrData),
    .digitsFlat(digitsFlat), .mode24(mode24), .leapPhase(leapPhase)
  );

  always_comb begin
    rdData = 4'd0;
    if (!rdBank) begin
      for (int i = 0; i < NUM_DIGITS; i++)
        if (rdAddr == 4'(i)) rdData = digitsFlat[i*NIB +: NIB];
    end else if (rdAddr == CFG_HOURMODE) begin
      rdData = {3'b000, mode24};
    end else if (rdAddr == CFG_PHASE) begin
      rdData = {2'b00, leapPhase};
    end
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      runEn,
  input logic                      wrEn,
  input logic                      advance,
  input logic                      wrTime,
  input logic                      wrCfg,
  input logic [NUM_DIGITS*NIB-1:0] digitsFlat
);
  assert_halt_no_advance_R9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !advance);

  assert_running_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> !(wrTime || wrCfg));

  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrEn) |=> $stable(digitsFlat));

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (advance && digitsFlat[3:0] != 4'd9) |=> (digitsFlat[3:0] == $past(digitsFlat[3:0]) + 4'd1));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .wrEn(wrEn),
  .advance(ctlStrobes.advance), .wrTime(ctlStrobes.wrTime), .wrCfg(ctlStrobes.wrCfg),
  .digitsFlat(digitsFlat)
);

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int CLK_PERIOD = 100;
  localparam int DIV = 4;

  logic clk = 1'b0, rstN = 1'b0, runEn = 1'b0, divReset = 1'b0;
  logic wrEn = 1'b0, wrBank = 1'b0, rdBank = 1'b0;
  logic [3:0] wrAddr = 4'd0, wrData = 4'd0, rdAddr = 4'd0;
  logic [3:0] rdData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural model state
  int md [13];
  int mMode, mPhase, mPcnt, mOwed;

  rtc_calendar #(.TICK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .divReset(divReset), .wrEn(wrEn),
    .wrBank(wrBank), .wrAddr(wrAddr), .wrData(wrData), .rdBank(rdBank),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int monthDays(int mon, int phase);
    case (mon)
      2: return (phase == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic modelStep();
    int s, mi, h24, h12, pm, d, mo, y;
    s  = md[1] * 10 + md[0];
    mi = md[3] * 10 + md[2];
    if (mMode == 1) h24 = md[5] * 10 + md[4];
    else begin
      h12 = (md[5] % 2) * 10 + md[4];
      pm  = (md[5] / 2) % 2;
      h24 = (h12 % 12) + (pm ? 12 : 0);
    end
    d  = md[8] * 10 + md[7];
    mo = md[10] * 10 + md[9];
    y  = md[12] * 10 + md[11];
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h24++;
        if (h24 == 24) begin
          h24 = 0;
          md[6] = (md[6] + 1) % 7;
          d++;
          if (d > monthDays(mo, mPhase)) begin
            d = 1; mo++;
            if (mo == 13) begin
              mo = 1; y = (y + 1) % 100; mPhase = (mPhase + 1) % 4;
            end
          end
        end
      end
    end
    md[0] = s % 10;  md[1] = s / 10;
    md[2] = mi % 10; md[3] = mi / 10;
    if (mMode == 1) begin
      md[4] = h24 % 10; md[5] = h24 / 10;
    end else begin
      pm  = (h24 >= 12) ? 1 : 0;
      h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
      md[4] = h12 % 10; md[5] = pm * 2 + h12 / 10;
    end
    md[7] = d % 10;  md[8] = d / 10;
    md[9] = mo % 10; md[10] = mo / 10;
    md[11] = y % 10; md[12] = y / 10;
  endtask

  always @(posedge clk) begin
    bit tick;
    if (!rstN) begin
      foreach (md[i]) md[i] = 0;
      md[7] = 1; md[9] = 1;
      mMode = 1; mPhase = 0; mPcnt = 0; mOwed = 0;
    end else begin
      tick  = (mPcnt == DIV - 1) && !divReset;
      mPcnt = (divReset || mPcnt == DIV - 1) ? 0 : mPcnt + 1;
      if (tick) mOwed++;
      if (runEn) begin
        if (mOwed > 0) begin modelStep(); mOwed--; end
      end else begin
        if (mOwed > 1) mOwed = 1;
        if (wrEn) begin
          if (!wrBank && wrAddr < 13) md[wrAddr] = int'(wrData);
          else if (wrBank && wrAddr == 4'd10) mMode = int'(wrData[0]);
          else if (wrBank && wrAddr == 4'd11) mPhase = int'(wrData[1:0]);
        end
      end
    end
  end

  function automatic int expRead(int b, int a);
    if (b == 0) return (a < 13) ? md[a] : 0;
    if (a == 10) return mMode;
    if (a == 11) return mPhase;
    return 0;
  endfunction

  task automatic check(string req, int b, int a, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s bank %0d addr %0d: actual %0d expected %0d at %0t", req, b, a, act, exp, $time);
    end
  endtask

  // compare every readable nibble once per clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int b = 0; b < 2; b++) begin
        for (int a = 0; a < 16; a++) begin
          bit unused;
          rdBank = b[0];
          rdAddr = a[3:0];
          #1;
          unused = (b == 0) ? (a >= 13) : (a != 10 && a != 11);
          check(unused ? "R12" : curReq, b, a, int'(rdData), expRead(b, a));
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setRun(logic v);
    @(negedge clk); #2 runEn = v;
  endtask

  task automatic wr(logic bank, int addr, int data);
    @(negedge clk); #2;
    wrEn = 1'b1; wrBank = bank; wrAddr = addr[3:0]; wrData = data[3:0];
    @(negedge clk); #2;
    wrEn = 1'b0;
  endtask

  // hT/hU are raw hour nibbles so 12-hour loads can carry the PM bit
  task automatic setTime(int hT, int hU, int mi, int s, int d, int mo, int y, int wd);
    wr(0, 0, s % 10);  wr(0, 1, s / 10);
    wr(0, 2, mi % 10); wr(0, 3, mi / 10);
    wr(0, 4, hU);      wr(0, 5, hT);
    wr(0, 6, wd);
    wr(0, 7, d % 10);  wr(0, 8, d / 10);
    wr(0, 9, mo % 10); wr(0, 10, mo / 10);
    wr(0, 11, y % 10); wr(0, 12, y / 10);
  endtask

  task automatic waitPcnt(int target, int owed);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(mPcnt == target && (owed < 0 || mOwed == owed)) && guard < 100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(3);
    #2 rstN = 1'b1;
    curReq = "R1"; idle(2);

    curReq = "R2"; setRun(1); idle(12 * DIV);
    setRun(0); setTime(0, 0, 58, 55, 5, 3, 20, 2); setRun(1); idle(8 * DIV);

    curReq = "R8";
    wr(0, 0, 7); wr(1, 10, 0); wr(1, 11, 3); idle(2);

    curReq = "R3";
    setRun(0); wr(1, 11, 3); setTime(2, 3, 59, 58, 31, 12, 99, 6); setRun(1); idle(4 * DIV);

    curReq = "R5";
    setRun(0); setTime(2, 3, 59, 59, 30, 4, 5, 1); setRun(1); idle(3 * DIV);
    setRun(0); setTime(2, 3, 59, 59, 31, 5, 5, 1); setRun(1); idle(3 * DIV);

    curReq = "R6";
    setRun(0); wr(1, 11, 1); setTime(2, 3, 59, 59, 28, 2, 13, 3); setRun(1); idle(3 * DIV);
    setRun(0); wr(1, 11, 0); setTime(2, 3, 59, 59, 28, 2, 16, 3); setRun(1); idle(3 * DIV);
    setRun(0); setTime(2, 3, 59, 59, 29, 2, 16, 3); setRun(1); idle(3 * DIV);
    setRun(0); wr(1, 11, 2); setTime(2, 3, 59, 59, 31, 12, 45, 0); setRun(1); idle(3 * DIV);

    curReq = "R7";
    setRun(0); setTime(2, 3, 59, 59, 10, 7, 30, 6); setRun(1); idle(3 * DIV);

    curReq = "R4";
    setRun(0); wr(1, 10, 0); setTime(1, 1, 59, 59, 10, 7, 30, 2); setRun(1); idle(3 * DIV);
    setRun(0); setTime(3, 2, 59, 59, 10, 7, 30, 2); setRun(1); idle(3 * DIV);
    setRun(0); setTime(3, 1, 59, 59, 10, 7, 30, 2); setRun(1); idle(3 * DIV);
    setRun(0); setTime(0, 9, 59, 59, 10, 7, 30, 2); setRun(1); idle(3 * DIV);
    setRun(0); wr(1, 10, 1); setTime(0, 0, 0, 0, 1, 1, 0, 0);

    curReq = "R9";
    idle(5 * DIV); setRun(1); idle(2 * DIV);
    setRun(0); idle(DIV / 2); setRun(1); idle(2 * DIV);

    curReq = "R10";
    setRun(0); idle(2 * DIV);
    waitPcnt(DIV - 1, 1);
    #2 runEn = 1'b1;
    idle(3 * DIV);

    curReq = "R11";
    idle(1); #2 divReset = 1'b1; @(negedge clk); #2 divReset = 1'b0; idle(3 * DIV);
    waitPcnt(DIV - 1, -1);
    #2 divReset = 1'b1; @(negedge clk); #2 divReset = 1'b0; idle(3 * DIV);
    waitPcnt(DIV - 2, -1);
    #2 divReset = 1'b1; @(negedge clk); #2 divReset = 1'b0; idle(3 * DIV);

    curReq = "R12"; idle(2);

    @(negedge clk); #40;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule